// File: doc/BRIEF.md
# Shared Interrupt Line Configuration Bank

This block holds the software-visible configuration of the shared peripheral interrupt lines of an interrupt distributor. Lines carry identifiers from 32 upward; the number of lines actually built is the parameter `NUM_SPI` (at most 988, so the highest identifier is 1019). For every line the bank keeps an enable bit, an 8-bit priority, a 2-bit trigger configuration and a 64-bit processor affinity route. All of it is driven continuously onto flat per-line output vectors, where the arbitration logic next to this bank picks it up. Line `k` of every vector belongs to identifier `32 + k`.

Software reaches the bank through a register port with a valid/ready request and a registered read response. It can issue 32-bit and 64-bit accesses. The port also holds a small control register with three group/routing enables, and a read-only type word that describes the build. Enables are never written directly. A write-one-to-set window turns enables on and a write-one-to-clear window turns them off. A busy flag in the control register stays up for `PEND_CYCLES` cycles after a control write or any write into the clear window. Software polls this flag until it drops before it assumes the change has reached the interrupt fabric.

Top module: `sid_regbank`

## Requirements
- R1: After reset, every line enable, priority, trigger configuration and route is zero, the control register reads zero and the busy flag is low.
- R2: `req_ready` is always high. A read accepted at a clock edge gives `rsp_valid` high with its data after that same edge, for one cycle. A write changes state at the edge that accepts it and produces no response.
- R3: The control word (offset 0x000) stores write data bits 0, 1 and 4, reads them back in the same positions, reads bit 31 as the busy flag and reads all other bits as zero.
- R4: The type word (offset 0x004) reads `(ID_BITS-1)` in bits 23:19 and `ceil((32+NUM_SPI)/32)-1` in bits 4:0. Writes to it are ignored.
- R5: A 1 written to bit `b` of set word `w` (offset 0x100+4w) enables identifier `32w+b`. A written 0 leaves the enable unchanged. The word reads back the current enables.
- R6: A 1 written to bit `b` of clear word `w` (offset 0x180+4w) disables identifier `32w+b`. A written 0 leaves it unchanged. The word reads back the same enables as the set window.
- R7: Priority word `w` (offset 0x400+4w) holds identifier `4w+j` in bits `8j+7:8j`, fully writable and readable.
- R8: Configuration word `w` (offset 0xC00+4w) holds identifier `16w+j` in bits `2j+1:2j`. Bit `2j` selects polarity (0 low, 1 high) and bit `2j+1` selects trigger (0 level, 1 edge).
- R9: The route of identifier `n` sits at offset 0x6000+8n. A 64-bit access (`req_wide`=1) moves all 64 bits. A 32-bit access at +0 or +4 moves the low or high half in data bits 31:0, and the read is zero-extended.
- R10: The busy flag (control bit 31) reads 1 on exactly the next `PEND_CYCLES` reads accepted back-to-back after a control write or a clear-window write. Another such write restarts the count. Set-window writes do not raise it.
- R11: Identifiers below 32 or at or above `32+NUM_SPI`, unmapped offsets and offsets that are not 4-byte aligned read as zero and ignore writes.
- R12: `line_en[k]`, `line_prio[8k+7:8k]`, `line_cfg[2k+1:2k]` and `line_route[64k+63:64k]` show the stored state of identifier `32+k`, updated at the edge that accepts the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Register access request |
| req_ready | output | 1 | Request accepted (always 1) |
| req_write | input | 1 | 1 write, 0 read |
| req_wide | input | 1 | 1 for 64-bit access, 0 for 32-bit |
| req_addr | input | 16 | Byte offset |
| req_wdata | input | 64 | Write data (bits 31:0 for 32-bit access) |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 64 | Read data |
| line_en | output | NUM_SPI | Per-line enable |
| line_prio | output | 8*NUM_SPI | Per-line priority, 0x00 most urgent |
| line_cfg | output | 2*NUM_SPI | Per-line polarity/trigger |
| line_route | output | 64*NUM_SPI | Per-line affinity route |

## Verification
Read data is due one edge after the read is accepted, so the bench drives each request just after a falling edge and samples the response at the next falling edge. The per-line outputs change at the edge that accepts the write, so they are sampled at the falling edge that follows. The busy flag is checked by issuing reads back to back after the triggering write. Read `k` is accepted `k` edges after the write and must show the flag for `k` up to `PEND_CYCLES` and not at `PEND_CYCLES+1`. A restart case repeats the check with a second clear-window write issued mid-count.

// File: rtl/sid_pkg.sv
package sid_pkg;

  localparam int FIRST_ID  = 32;
  localparam int LAST_ID   = 1019;
  localparam int IDW       = 11;

  typedef enum logic [2:0] {
    K_NONE,
    K_CTRL,
    K_TYPE,
    K_ESET,
    K_ECLR,
    K_PRIO,
    K_CFG,
    K_ROUTE
  } reg_kind_e;

endpackage

// File: rtl/sid_decode.sv
module sid_decode
  import sid_pkg::*;
(
  input  logic [15:0]    addr,
  output reg_kind_e      kind,
  output logic [IDW-1:0] id_base,
  output logic           route_hi
);

  always_comb begin
    kind     = K_NONE;
    id_base  = '0;
    route_hi = 1'b0;
    if (addr[1:0] == 2'b00) begin
      if (addr == 16'h0000) begin
        kind = K_CTRL;
      end else if (addr == 16'h0004) begin
        kind = K_TYPE;
      end else if (addr[15:7] == 9'h002) begin
        kind    = K_ESET;
        id_base = {addr[6:2], 6'b0} >> 1;
      end else if (addr[15:7] == 9'h003) begin
        kind    = K_ECLR;
        id_base = {addr[6:2], 6'b0} >> 1;
      end else if (addr[15:10] == 6'h01) begin
        kind    = K_PRIO;
        id_base = {1'b0, addr[9:2], 2'b0};
      end else if (addr[15:8] == 8'h0C) begin
        kind    = K_CFG;
        id_base = {1'b0, addr[7:2], 4'b0};
      end else if (addr[15:13] == 3'b011) begin
        kind     = K_ROUTE;
        id_base  = {1'b0, addr[12:3]};
        route_hi = addr[2];
      end
    end
  end

endmodule

// File: rtl/sid_pend_timer.sv
module sid_pend_timer #(
  parameter int PEND_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  output logic pend
);

  localparam int CW = $clog2(PEND_CYCLES + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = trig || (cnt_q != '0);
    cnt_d  = cnt_q;
    if (trig) begin
      cnt_d = CW'(PEND_CYCLES);
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign pend = (cnt_q != '0);

  // R10: a trigger always raises the flag on the next cycle
  a_r10_trig_raises: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> pend);

  // R10: the count never exceeds the configured window
  a_r10_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(PEND_CYCLES));

endmodule

// File: rtl/sid_line_store.sv
module sid_line_store
  import sid_pkg::*;
#(
  parameter int NUM_SPI = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr,
  input  reg_kind_e          kind,
  input  logic [IDW-1:0]     id_base,
  input  logic               route_hi,
  input  logic               wide,
  input  logic [63:0]        wdata,
  output logic [NUM_SPI-1:0] en_q,
  output logic [7:0]         prio_q  [NUM_SPI],
  output logic [1:0]         cfg_q   [NUM_SPI],
  output logic [63:0]        route_q [NUM_SPI]
);

  for (genvar i = 0; i < NUM_SPI; i++) begin : g_line
    localparam int LID = FIRST_ID + i;
    localparam logic [IDW-1:0] B32 = IDW'(LID - (LID % 32));
    localparam logic [IDW-1:0] B4  = IDW'(LID - (LID % 4));
    localparam logic [IDW-1:0] B16 = IDW'(LID - (LID % 16));
    localparam logic [IDW-1:0] B1  = IDW'(LID);

    logic        en_d, en_ce;
    logic [7:0]  prio_d;
    logic        prio_ce;
    logic [1:0]  cfg_d;
    logic        cfg_ce;
    logic [63:0] route_d;
    logic        route_ce;

    always_comb begin
      en_ce    = 1'b0;
      en_d     = en_q[i];
      if (wr && (kind == K_ESET) && (id_base == B32) && wdata[LID % 32]) begin
        en_ce = 1'b1;
        en_d  = 1'b1;
      end else if (wr && (kind == K_ECLR) && (id_base == B32) && wdata[LID % 32]) begin
        en_ce = 1'b1;
        en_d  = 1'b0;
      end
      prio_ce  = wr && (kind == K_PRIO) && (id_base == B4);
      prio_d   = wdata[8*(LID % 4) +: 8];
      cfg_ce   = wr && (kind == K_CFG) && (id_base == B16);
      cfg_d    = wdata[2*(LID % 16) +: 2];
      route_ce = wr && (kind == K_ROUTE) && (id_base == B1);
      if (wide) begin
        route_d = wdata;
      end else if (route_hi) begin
        route_d = {wdata[31:0], route_q[i][31:0]};
      end else begin
        route_d = {route_q[i][63:32], wdata[31:0]};
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        en_q[i]    <= 1'b0;
        prio_q[i]  <= '0;
        cfg_q[i]   <= '0;
        route_q[i] <= '0;
      end else begin
        if (en_ce)    en_q[i]    <= en_d;
        if (prio_ce)  prio_q[i]  <= prio_d;
        if (cfg_ce)   cfg_q[i]   <= cfg_d;
        if (route_ce) route_q[i] <= route_d;
      end
    end

    // R5: an enable only rises through a set-window write
    a_r5_en_rise: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(en_q[i]) |-> $past(wr && kind == K_ESET));

    // R6: an enable only falls through a clear-window write
    a_r6_en_fall: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(en_q[i]) |-> $past(wr && kind == K_ECLR));

    // R7: priority holds unless a priority word is written
    a_r7_prio_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr && kind == K_PRIO) |=> $stable(prio_q[i]));
  end

endmodule

// File: rtl/sid_readmux.sv
module sid_readmux
  import sid_pkg::*;
#(
  parameter int NUM_SPI = 64,
  parameter int ID_BITS = 10
) (
  input  reg_kind_e          kind,
  input  logic [IDW-1:0]     id_base,
  input  logic               route_hi,
  input  logic               wide,
  input  logic [2:0]         ctrl_q,
  input  logic               pend,
  input  logic [NUM_SPI-1:0] en_q,
  input  logic [7:0]         prio_q  [NUM_SPI],
  input  logic [1:0]         cfg_q   [NUM_SPI],
  input  logic [63:0]        route_q [NUM_SPI],
  output logic [63:0]        rdata
);

  localparam int LW         = (NUM_SPI > 1) ? $clog2(NUM_SPI) : 1;
  localparam int LINE_FIELD = ((FIRST_ID + NUM_SPI + 31) / 32) - 1;
  localparam logic [31:0] TYPE_VAL =
    (32'(ID_BITS - 1) << 19) | 32'(LINE_FIELD);

  function automatic logic in_rng(input int id);
    return (id >= FIRST_ID) && (id < FIRST_ID + NUM_SPI);
  endfunction

  always_comb begin
    rdata = '0;
    case (kind)
      K_CTRL: rdata[31:0] = {pend, 26'b0, ctrl_q[2], 2'b0, ctrl_q[1], ctrl_q[0]};
      K_TYPE: rdata[31:0] = TYPE_VAL;
      K_ESET, K_ECLR: begin
        for (int b = 0; b < 32; b++) begin
          if (in_rng(int'(id_base) + b)) begin
            rdata[b] = en_q[LW'(int'(id_base) + b - FIRST_ID)];
          end
        end
      end
      K_PRIO: begin
        for (int j = 0; j < 4; j++) begin
          if (in_rng(int'(id_base) + j)) begin
            rdata[8*j +: 8] = prio_q[LW'(int'(id_base) + j - FIRST_ID)];
          end
        end
      end
      K_CFG: begin
        for (int j = 0; j < 16; j++) begin
          if (in_rng(int'(id_base) + j)) begin
            rdata[2*j +: 2] = cfg_q[LW'(int'(id_base) + j - FIRST_ID)];
          end
        end
      end
      K_ROUTE: begin
        if (in_rng(int'(id_base))) begin
          if (wide) begin
            rdata = route_q[LW'(int'(id_base) - FIRST_ID)];
          end else if (route_hi) begin
            rdata[31:0] = route_q[LW'(int'(id_base) - FIRST_ID)][63:32];
          end else begin
            rdata[31:0] = route_q[LW'(int'(id_base) - FIRST_ID)][31:0];
          end
        end
      end
      default: rdata = '0;
    endcase
  end

endmodule

// File: rtl/sid_regbank.sv
module sid_regbank
  import sid_pkg::*;
#(
  parameter int NUM_SPI     = 64,
  parameter int ID_BITS     = 10,
  parameter int PEND_CYCLES = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic                  req_write,
  input  logic                  req_wide,
  input  logic [15:0]           req_addr,
  input  logic [63:0]           req_wdata,
  output logic                  rsp_valid,
  output logic [63:0]           rsp_rdata,
  output logic [NUM_SPI-1:0]    line_en,
  output logic [8*NUM_SPI-1:0]  line_prio,
  output logic [2*NUM_SPI-1:0]  line_cfg,
  output logic [64*NUM_SPI-1:0] line_route
);

  reg_kind_e      kind;
  logic [IDW-1:0] id_base;
  logic           route_hi;
  logic           wr, rd;
  logic           pend, pend_trig;
  logic [2:0]     ctrl_q, ctrl_d;
  logic           ctrl_ce;
  logic [63:0]    rd_data;
  logic           rsp_valid_d;
  logic [63:0]    rsp_rdata_d;

  logic [NUM_SPI-1:0] en_q;
  logic [7:0]         prio_q  [NUM_SPI];
  logic [1:0]         cfg_q   [NUM_SPI];
  logic [63:0]        route_q [NUM_SPI];

  assign req_ready = 1'b1;
  assign wr        = req_valid && req_write;
  assign rd        = req_valid && !req_write;

  sid_decode u_decode (
    .addr     (req_addr),
    .kind     (kind),
    .id_base  (id_base),
    .route_hi (route_hi)
  );

  sid_line_store #(.NUM_SPI(NUM_SPI)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (wr),
    .kind     (kind),
    .id_base  (id_base),
    .route_hi (route_hi),
    .wide     (req_wide),
    .wdata    (req_wdata),
    .en_q     (en_q),
    .prio_q   (prio_q),
    .cfg_q    (cfg_q),
    .route_q  (route_q)
  );

  assign pend_trig = wr && ((kind == K_CTRL) || (kind == K_ECLR));

  sid_pend_timer #(.PEND_CYCLES(PEND_CYCLES)) u_pend (
    .clk   (clk),
    .rst_n (rst_n),
    .trig  (pend_trig),
    .pend  (pend)
  );

  sid_readmux #(.NUM_SPI(NUM_SPI), .ID_BITS(ID_BITS)) u_rmux (
    .kind     (kind),
    .id_base  (id_base),
    .route_hi (route_hi),
    .wide     (req_wide),
    .ctrl_q   (ctrl_q),
    .pend     (pend),
    .en_q     (en_q),
    .prio_q   (prio_q),
    .cfg_q    (cfg_q),
    .route_q  (route_q),
    .rdata    (rd_data)
  );

  // control register: {affinity routing, group 1 affinity, group 1}
  always_comb begin
    ctrl_ce     = wr && (kind == K_CTRL);
    ctrl_d      = {req_wdata[4], req_wdata[1], req_wdata[0]};
    rsp_valid_d = rd;
    rsp_rdata_d = rd_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      if (ctrl_ce) ctrl_q <= ctrl_d;
      rsp_valid <= rsp_valid_d;
      if (rd) rsp_rdata <= rsp_rdata_d;
    end
  end

  for (genvar k = 0; k < NUM_SPI; k++) begin : g_flat
    assign line_en[k]             = en_q[k];
    assign line_prio[8*k +: 8]    = prio_q[k];
    assign line_cfg[2*k +: 2]     = cfg_q[k];
    assign line_route[64*k +: 64] = route_q[k];
  end

  // R2: every accepted read is answered on the next cycle
  a_r2_rsp_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rsp_valid);

  // R2: no response without a read
  a_r2_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid && !req_write));

  // R12: enables never move without a write
  a_r12_en_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_write) |=> $stable(line_en));

  // R3: reserved control bits read as zero
  a_r3_ctrl_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && $past(req_addr == 16'h0000)) |->
      (rsp_rdata[30:5] == '0) && (rsp_rdata[3:2] == '0) && (rsp_rdata[63:32] == '0));

  // R11: unmapped offsets read zero
  a_r11_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && $past(kind == K_NONE)) |-> (rsp_rdata == '0));

endmodule

// File: tb/sid_regbank_tb.sv
`timescale 1ns/1ps
module sid_regbank_tb;

  localparam int NUM_SPI = 64;
  localparam int PEND    = 8;

  logic                  clk = 1'b0;
  logic                  rst_n;
  logic                  req_valid, req_write, req_wide;
  logic                  req_ready;
  logic [15:0]           req_addr;
  logic [63:0]           req_wdata;
  logic                  rsp_valid;
  logic [63:0]           rsp_rdata;
  logic [NUM_SPI-1:0]    line_en;
  logic [8*NUM_SPI-1:0]  line_prio;
  logic [2*NUM_SPI-1:0]  line_cfg;
  logic [64*NUM_SPI-1:0] line_route;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  sid_regbank #(.NUM_SPI(NUM_SPI), .ID_BITS(10), .PEND_CYCLES(PEND)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_wide(req_wide), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .line_en(line_en), .line_prio(line_prio), .line_cfg(line_cfg),
    .line_route(line_route)
  );

  typedef struct packed {
    logic        wr;
    logic        wide;
    logic [15:0] addr;
    logic [63:0] data;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 33;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b0, 16'h0104, 64'h5,                   8'd5},  // R5 set IDs 32,34
    '{1'b0, 1'b0, 16'h0104, 64'h5,                   8'd5},  // R5
    '{1'b0, 1'b0, 16'h0184, 64'h5,                   8'd6},  // R6 clear window reads state
    '{1'b1, 1'b0, 16'h0184, 64'h1,                   8'd6},  // R6 clear ID 32
    '{1'b0, 1'b0, 16'h0104, 64'h4,                   8'd6},  // R6
    '{1'b1, 1'b0, 16'h0104, 64'h0,                   8'd5},  // R5 zeros no effect
    '{1'b0, 1'b0, 16'h0104, 64'h4,                   8'd5},  // R5
    '{1'b1, 1'b0, 16'h0108, 64'h8000_0000,           8'd5},  // R5 ID 95
    '{1'b0, 1'b0, 16'h0108, 64'h8000_0000,           8'd5},  // R5
    '{1'b1, 1'b0, 16'h010C, 64'hFFFF_FFFF,           8'd11}, // R11 IDs 96+
    '{1'b0, 1'b0, 16'h010C, 64'h0,                   8'd11}, // R11
    '{1'b1, 1'b0, 16'h0100, 64'hFFFF_FFFF,           8'd11}, // R11 IDs 0..31
    '{1'b0, 1'b0, 16'h0100, 64'h0,                   8'd11}, // R11
    '{1'b1, 1'b0, 16'h0420, 64'h4433_2211,           8'd7},  // R7 IDs 32..35
    '{1'b0, 1'b0, 16'h0420, 64'h4433_2211,           8'd7},  // R7
    '{1'b1, 1'b0, 16'h045C, 64'hA0B0_C0D0,           8'd7},  // R7 IDs 92..95
    '{1'b0, 1'b0, 16'h045C, 64'hA0B0_C0D0,           8'd7},  // R7
    '{1'b1, 1'b0, 16'h0460, 64'h1234_5678,           8'd11}, // R11
    '{1'b0, 1'b0, 16'h0460, 64'h0,                   8'd11}, // R11
    '{1'b1, 1'b0, 16'h0C08, 64'h9,                   8'd8},  // R8 IDs 32..47
    '{1'b0, 1'b0, 16'h0C08, 64'h9,                   8'd8},  // R8
    '{1'b1, 1'b1, 16'h6100, 64'h0000_00AB_0000_0102, 8'd9},  // R9 ID 32 wide
    '{1'b0, 1'b1, 16'h6100, 64'h0000_00AB_0000_0102, 8'd9},  // R9
    '{1'b0, 1'b0, 16'h6104, 64'h0000_00AB,           8'd9},  // R9 high half
    '{1'b1, 1'b0, 16'h6100, 64'h777,                 8'd9},  // R9 low half write
    '{1'b0, 1'b1, 16'h6100, 64'h0000_00AB_0000_0777, 8'd9},  // R9
    '{1'b1, 1'b1, 16'h6300, 64'hFFFF,                8'd11}, // R11 ID 96
    '{1'b0, 1'b1, 16'h6300, 64'h0,                   8'd11}, // R11
    '{1'b0, 1'b0, 16'h0004, 64'h0048_0002,           8'd4},  // R4
    '{1'b0, 1'b0, 16'h0200, 64'h0,                   8'd11}, // R11 unmapped
    '{1'b0, 1'b0, 16'h0106, 64'h0,                   8'd11}, // R11 misaligned read
    '{1'b1, 1'b0, 16'h0106, 64'hFFFF_FFFF,           8'd11}, // R11 misaligned write
    '{1'b0, 1'b0, 16'h0104, 64'h4,                   8'd11}  // R11
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic xact(input logic wr, input logic wide, input logic [15:0] a,
                      input logic [63:0] d, output logic [63:0] rd, output logic rv);
    req_valid = 1'b1;
    req_write = wr;
    req_wide  = wide;
    req_addr  = a;
    req_wdata = d;
    @(negedge clk);
    rd = rsp_rdata;
    rv = rsp_valid;
    req_valid = 1'b0;
    req_write = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    logic [63:0] rd;
    logic        rv;
    req_valid = 1'b0; req_write = 1'b0; req_wide = 1'b0;
    req_addr = '0; req_wdata = '0;
    rst_n = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R1 reset state at the outputs
    check("R1 en",    64'(line_en), 64'h0);
    check("R1 prio",  64'(line_prio != '0), 64'h0);
    check("R1 cfg",   64'(line_cfg != '0), 64'h0);
    check("R1 route", 64'(line_route != '0), 64'h0);
    check("R2 ready", 64'(req_ready), 64'h1);
    xact(1'b0, 1'b0, 16'h0000, 64'h0, rd, rv);
    check("R1 ctrl", rd, 64'h0);
    check("R2 rsp_valid", 64'(rv), 64'h1);
    idle(1);
    check("R2 rsp drops", 64'(rsp_valid), 64'h0);

    // table walk
    for (int v = 0; v < NV; v++) begin
      xact(VECS[v].wr, VECS[v].wide, VECS[v].addr, VECS[v].data, rd, rv);
      if (VECS[v].wr) begin
        check($sformatf("R2 no rsp on write R%0d", VECS[v].req), 64'(rv), 64'h0);
      end else begin
        check($sformatf("R%0d vec %0d", VECS[v].req, v), rd, VECS[v].data);
      end
    end

    // R12 per-line outputs
    check("R12 en ID32", 64'(line_en[0]), 64'h0);
    check("R12 en ID34", 64'(line_en[2]), 64'h1);
    check("R12 en ID95", 64'(line_en[63]), 64'h1);
    check("R12 prio ID32", 64'(line_prio[7:0]), 64'h11);
    check("R12 prio ID95", 64'(line_prio[511:504]), 64'hA0);
    check("R12 cfg ID32", 64'(line_cfg[1:0]), 64'h1);
    check("R12 cfg ID33", 64'(line_cfg[3:2]), 64'h2);
    check("R12 route ID32", line_route[63:0], 64'h0000_00AB_0000_0777);

    // R3 / R10: control write then back-to-back reads
    idle(PEND + 2);
    xact(1'b1, 1'b0, 16'h0000, 64'hFFFF_FFFF, rd, rv);
    for (int k = 1; k <= PEND + 1; k++) begin
      xact(1'b0, 1'b0, 16'h0000, 64'h0, rd, rv);
      check($sformatf("R10 R3 busy read %0d", k), rd,
            (k <= PEND) ? 64'h8000_0013 : 64'h13);
    end

    // R10: set-window write does not raise busy
    xact(1'b1, 1'b0, 16'h0104, 64'h2, rd, rv);
    xact(1'b0, 1'b0, 16'h0000, 64'h0, rd, rv);
    check("R10 set no busy", rd, 64'h13);

    // R10: restart by a second clear-window write
    xact(1'b1, 1'b0, 16'h0184, 64'h0, rd, rv);
    idle(4);
    xact(1'b1, 1'b0, 16'h0184, 64'h0, rd, rv);
    for (int k = 1; k <= PEND + 1; k++) begin
      xact(1'b0, 1'b0, 16'h0000, 64'h0, rd, rv);
      if (k >= PEND)
        check($sformatf("R10 restart read %0d", k), rd,
              (k <= PEND) ? 64'h8000_0013 : 64'h13);
    end

    // R3 control bits clear
    xact(1'b1, 1'b0, 16'h0000, 64'h0, rd, rv);
    idle(PEND + 1);
    xact(1'b0, 1'b0, 16'h0000, 64'h0, rd, rv);
    check("R3 ctrl cleared", rd, 64'h0);
    // R4 type word ignores writes
    xact(1'b1, 1'b0, 16'h0004, 64'hFFFF_FFFF, rd, rv);
    xact(1'b0, 1'b0, 16'h0004, 64'h0, rd, rv);
    check("R4 type write ignored", rd, 64'h0048_0002);

    // R1 reset clears state again
    rst_n = 1'b0;
    idle(1);
    rst_n = 1'b1;
    idle(1);
    check("R1 en after reset", 64'(line_en), 64'h0);
    check("R1 route after reset", 64'(line_route != '0), 64'h0);

    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

endmodule